// File: doc/BRIEF.md
# Multi-Module Start Trigger Synchronizer

Several waveform generator modules must begin playback on the same instant. Each module divides its fast sample clock down to a slow trigger clock whose period is at least 100 ns. A coarse alignment offset presets the divider phase in whole sample cycles, so that the trigger clocks of all modules can be lined up against a common reference. One module is selected as master. When its arm bit is set, it drives one start pulse onto a shared trigger line. The pulse begins just after a falling edge of its trigger clock and lasts one full trigger-clock period.

Every module, the master included, samples the shared line through a two-flop synchronizer and arms on the pulse's leading edge. It then fires a one-cycle start strobe on the next trigger-clock rising edge. Launching on the falling edge and capturing on the rising edge gives the line half a slow period to settle across all modules. Playback stays asserted until a stop input arrives. A playback address counter begins at a rotated start point, which gives a phase shift coarser than a whole sample. A positive rotation starts partway into the waveform, and a negative rotation starts that many samples before its end.

Top module: `trig_sync_top`

## Requirements
- R1: While reset is low and in the first cycle after it, trig_out, start_pulse and playing are 0, play_addr is 0, and tclk is 1. The trigger clock begins in its high half.
- R2: With an effective half period H, tclk repeats a pattern of 2·H sample cycles: H cycles high followed by H cycles low.
- R3: A div_half value below MIN_HALF (5 by default) is treated as MIN_HALF, so the trigger-clock period is never shorter than 2·MIN_HALF cycles.
- R4: A cycle with align_load high sets the divider phase to align_ofs, where phase 0 is the first high cycle. In the cycle after the load, tclk equals ((align_ofs + j) mod 2H) < H at the j-th cycle after the load. An offset of 2H or more loads phase 0.
- R5: A master with arm high drives trig_out high starting in the second low cycle of tclk. trig_out stays high for exactly 2·H cycles, and only one pulse is sent for each time arm is asserted.
- R6: When is_master is 0, trig_out stays 0 whatever arm does.
- R7: After a rising edge on the synchronized trigger line, start_pulse is high for exactly one cycle. That cycle is the second high cycle of tclk, at the first tclk rising edge that follows the line edge. playing rises in the same cycle.
- R8: Further line edges are ignored while a start is pending or playback is running: a second edge before the start still gives one start_pulse, and an edge during playback gives none.
- R9: stop makes playing 0 in the following cycle, and it also cancels a pending start.
- R10: At start_pulse, play_addr equals rot_ofs when rot_ofs ≥ 0, and wave_len + rot_ofs when rot_ofs < 0. rot_ofs is read as two's complement with |rot_ofs| < wave_len. On each later playing cycle, play_addr advances by 1 and wraps from wave_len−1 to 0.
- R11: A master whose trig_in is fed from its own trig_out starts at the first tclk rising edge after its own launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_half | input | DIV_W | Trigger-clock half period in sample cycles (runtime) |
| align_load | input | 1 | Preset the divider phase from align_ofs |
| align_ofs | input | DIV_W+1 | Coarse alignment offset in sample cycles |
| is_master | input | 1 | 1 selects this module as trigger source |
| arm | input | 1 | Software arm bit for the master launch |
| trig_in | input | 1 | Shared trigger line, asynchronous |
| trig_out | output | 1 | Drive onto the shared trigger line |
| tclk | output | 1 | Derived trigger clock |
| stop | input | 1 | Ends playback or cancels a pending start |
| wave_len | input | AW | Waveform length in samples |
| rot_ofs | input | AW+1 | Signed start-point rotation |
| start_pulse | output | 1 | One-cycle playback start strobe |
| playing | output | 1 | Playback active |
| play_addr | output | AW | Current playback sample address |

## Verification
The bench uses DIV_W = 8, MIN_HALF = 5 and AW = 6, with a runtime half period of 6, so one trigger-clock period is 12 sample cycles. Windows of a few periods cover launch, settle, capture and restart in a few hundred cycles. Half periods of 2 and 0 exercise the clamp, and an offset of 2H or more exercises the out-of-range load. A 7-sample waveform with rotations of +3, −2 and 0 wraps the address counter several times within each window.

// File: rtl/trig_sync_pkg.sv
// Shared types for the start trigger synchronizer.
// Assumes nothing beyond IEEE 1800-2017 package support.
package trig_sync_pkg;

    // Playback controller states
    typedef enum logic [1:0] {
        PS_IDLE    = 2'd0,
        PS_PENDING = 2'd1,
        PS_PLAYING = 2'd2
    } play_state_t;

endpackage

// File: rtl/tsync_divider.sv
// Trigger-clock divider: counts sample cycles through a period of 2*H,
// high for phases 0..H-1 and low for H..2H-1. H is div_half clamped up to
// MIN_HALF. align_load presets the phase; out-of-range offsets load 0.
// Assumes div_half changes only when the phase may be disturbed.
module tsync_divider #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_half,
    input  logic             align_load,
    input  logic [DIV_W:0]   align_ofs,
    output logic             tclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] half_eff;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;

    // Clamp the half period and derive the full period
    always_comb begin
        half_eff = (div_half < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : div_half;
        period   = {half_eff, 1'b0};
    end

    // Phase counter with preset and wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (align_load) begin
            cnt <= (align_ofs < period) ? align_ofs : '0;
        end else if (cnt >= period - 1'b1) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tclk     = (cnt < {1'b0, half_eff});
    assign rise_stb = (cnt == '0);
    assign fall_stb = (cnt == {1'b0, half_eff});
endmodule

// File: rtl/tsync_launch.sv
// Master launcher: on a trigger-clock falling edge, with enable and arm set
// and no pulse yet sent for this arm, raises the line for one full
// trigger-clock period (falling edge to falling edge). Re-arming needs arm
// to drop first.
module tsync_launch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic arm,
    input  logic fall_stb,
    output logic line_q
);
    logic sent;

    // Launch, hold and end the line pulse; track one pulse per arm
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            sent   <= 1'b0;
        end else begin
            if (!arm) begin
                sent <= 1'b0;
            end
            if (fall_stb) begin
                if (line_q) begin
                    line_q <= 1'b0;
                end else if (enable && arm && !sent) begin
                    line_q <= 1'b1;
                    sent   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tsync_capture.sv
// Line receiver: SYNC_STAGES-flop synchronizer on the asynchronous trigger
// line plus a rising-edge detector behind it. Assumes line pulses last
// several sample cycles.
module tsync_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic edge_stb
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh;

    // Synchronizer chain with one extra stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[SH_W-2:0], line_in};
        end
    end

    assign edge_stb = sh[SH_W-2] & ~sh[SH_W-1];
endmodule

// File: rtl/tsync_play.sv
// Playback controller: an edge arms a pending start; the next trigger-clock
// rising edge issues a one-cycle start and enters playback; stop returns to
// idle. Edges seen while pending or playing are ignored. The playback
// address starts at the rotated start point and wraps at wave_len.
// Assumes |rot_ofs| < wave_len and both stable during playback.
module tsync_play
    import trig_sync_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_stb,
    input  logic          rise_stb,
    input  logic          stop,
    input  logic [AW-1:0] wave_len,
    input  logic [AW:0]   rot_ofs,
    output logic          start_pulse,
    output logic          playing,
    output logic [AW-1:0] play_addr
);
    play_state_t   state;
    logic [AW:0]   wrap_sum;
    logic [AW-1:0] start_addr;
    logic          at_last;

    // Rotated start point and end-of-waveform test
    always_comb begin
        wrap_sum   = {1'b0, wave_len} + rot_ofs;
        start_addr = rot_ofs[AW] ? wrap_sum[AW-1:0] : rot_ofs[AW-1:0];
        at_last    = (play_addr == wave_len - 1'b1);
    end

    // State sequencing, start strobe and address stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= PS_IDLE;
            start_pulse <= 1'b0;
            play_addr   <= '0;
        end else begin
            start_pulse <= 1'b0;
            case (state)
                PS_IDLE: begin
                    if (edge_stb) begin
                        state <= PS_PENDING;
                    end
                end
                PS_PENDING: begin
                    if (stop) begin
                        state <= PS_IDLE;
                    end else if (rise_stb) begin
                        state       <= PS_PLAYING;
                        start_pulse <= 1'b1;
                        play_addr   <= start_addr;
                    end
                end
                PS_PLAYING: begin
                    if (stop) begin
                        state <= PS_IDLE;
                    end else begin
                        play_addr <= at_last ? '0 : play_addr + 1'b1;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end

    assign playing = (state == PS_PLAYING);
endmodule

// File: rtl/trig_sync_top.sv
// Start trigger synchronizer top: divider, master launcher, line capture
// and playback controller. trig_in is the shared line as seen at this
// module, and includes this module's own trig_out when it is the master.
module trig_sync_top #(
    parameter int DIV_W       = 8,
    parameter int MIN_HALF    = 5,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_half,
    input  logic             align_load,
    input  logic [DIV_W:0]   align_ofs,
    input  logic             is_master,
    input  logic             arm,
    input  logic             trig_in,
    output logic             trig_out,
    output logic             tclk,
    input  logic             stop,
    input  logic [AW-1:0]    wave_len,
    input  logic [AW:0]      rot_ofs,
    output logic             start_pulse,
    output logic             playing,
    output logic [AW-1:0]    play_addr
);
    logic rise_stb;
    logic fall_stb;
    logic edge_stb;

    tsync_divider #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_half   (div_half),
        .align_load (align_load),
        .align_ofs  (align_ofs),
        .tclk       (tclk),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb)
    );

    tsync_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (is_master),
        .arm      (arm),
        .fall_stb (fall_stb),
        .line_q   (trig_out)
    );

    tsync_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (trig_in),
        .edge_stb (edge_stb)
    );

    tsync_play #(.AW(AW)) u_play (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_stb    (edge_stb),
        .rise_stb    (rise_stb),
        .stop        (stop),
        .wave_len    (wave_len),
        .rot_ofs     (rot_ofs),
        .start_pulse (start_pulse),
        .playing     (playing),
        .play_addr   (play_addr)
    );
endmodule

// File: rtl/tsync_checker.sv
// Temporal checks on the synchronizer's ports, bound into trig_sync_top.
module tsync_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tclk,
    input logic          trig_out,
    input logic          stop,
    input logic          start_pulse,
    input logic          playing,
    input logic [AW-1:0] play_addr,
    input logic [AW-1:0] wave_len
);
    assert_start_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    assert_start_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (tclk && $past(tclk) && !$past(tclk, 2)));

    assert_play_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(playing) |-> start_pulse);

    assert_launch_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> (!tclk && !$past(tclk)));

    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !playing);

    assert_addr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        playing |-> (play_addr < wave_len));
endmodule

bind trig_sync_top tsync_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tclk        (tclk),
    .trig_out    (trig_out),
    .stop        (stop),
    .start_pulse (start_pulse),
    .playing     (playing),
    .play_addr   (play_addr),
    .wave_len    (wave_len)
);

// File: tb/trig_sync_top_bench.sv
module trig_sync_top_bench;
    localparam int DIV_W = 8;
    localparam int AW    = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div_half = 8'd6;
    logic             align_load = 1'b0;
    logic [DIV_W:0]   align_ofs = '0;
    logic             is_master = 1'b0;
    logic             arm = 1'b0;
    logic             line_ext = 1'b0;
    logic             trig_in;
    logic             trig_out;
    logic             tclk;
    logic             stop = 1'b0;
    logic [AW-1:0]    wave_len = 6'd7;
    logic [AW:0]      rot_ofs = '0;
    logic             start_pulse;
    logic             playing;
    logic [AW-1:0]    play_addr;

    int checks = 0;
    int errors = 0;

    // Shared line: wired-OR of this module's drive and other modules
    assign trig_in = trig_out | line_ext;

    always #5 clk = ~clk;

    trig_sync_top u_trig_sync_top (
        .clk(clk), .rst_n(rst_n), .div_half(div_half), .align_load(align_load),
        .align_ofs(align_ofs), .is_master(is_master), .arm(arm), .trig_in(trig_in),
        .trig_out(trig_out), .tclk(tclk), .stop(stop), .wave_len(wave_len),
        .rot_ofs(rot_ofs), .start_pulse(start_pulse), .playing(playing),
        .play_addr(play_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Preset phase at a negedge; returns at the negedge of the first cycle after load
    task automatic do_align(input int ofs);
        @(negedge clk);
        align_ofs  = (DIV_W+1)'(ofs);
        align_load = 1'b1;
        @(negedge clk);
        align_load = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(trig_out == 0 && start_pulse == 0 && playing == 0, "R1 outputs in reset", playing, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tclk == 1, "R1 tclk after reset", tclk, 1);
        chk(trig_out == 0 && start_pulse == 0 && playing == 0 && play_addr == 0,
            "R1 idle after reset", play_addr, 0);
    endtask

    // Check 2P samples of tclk against the phase model
    task automatic check_phase(input int ofs, input int h, input int start_ph, input string req);
        int bad = 0;
        do_align(ofs);
        for (int j = 0; j < 4 * h; j++) begin
            if (j > 0) @(negedge clk);
            if (tclk != (((start_ph + j) % (2 * h)) < h)) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_divider();
        div_half = 8'd6;
        check_phase(0, 6, 0, "R2 period 12 pattern");
        div_half = 8'd8;
        check_phase(0, 8, 0, "R2 period 16 pattern");
        div_half = 8'd6;
    endtask

    task automatic t_clamp();
        div_half = 8'd2;
        check_phase(0, 5, 0, "R3 clamp from 2");
        div_half = 8'd0;
        check_phase(3, 5, 3, "R3 clamp from 0");
        div_half = 8'd6;
    endtask

    task automatic t_align();
        check_phase(4, 6, 4, "R4 offset 4");
        check_phase(9, 6, 9, "R4 offset 9");
        check_phase(15, 6, 0, "R4 offset out of range");
    endtask

    task automatic t_master();
        int launches = 0, hi = 0, starts = 0, start_n = -1, launch_n = -1, rise_n = -1;
        bit t1, t2, trp, tp;
        div_half = 8'd6;
        do_align(0);
        is_master = 1'b1;
        arm = 1'b1;
        t1 = tclk; t2 = tclk; trp = trig_out; tp = tclk;
        for (int n = 1; n <= 72; n++) begin
            @(negedge clk);
            if (trig_out && !trp) begin
                launches++;
                launch_n = n;
                chk(!tclk && !t1 && t2, "R5 launch in second low cycle", tclk, 0);
            end
            if (trig_out) hi++;
            if (tclk && !tp && launch_n >= 0 && rise_n < 0) rise_n = n;
            if (start_pulse) begin
                starts++;
                start_n = n;
            end
            t2 = t1; t1 = tclk; tp = tclk; trp = trig_out;
        end
        chk(launches == 1, "R5 one pulse per arm", launches, 1);
        chk(hi == 12, "R5 pulse length one period", hi, 12);
        chk(starts == 1, "R11 master self start count", starts, 1);
        chk(start_n == rise_n + 1, "R11 start at first rise after launch", start_n, rise_n + 1);
        chk(playing == 1, "R7 playing after start", playing, 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(playing == 0, "R9 stop ends playback", playing, 0);
        arm = 1'b0;
        is_master = 1'b0;
    endtask

    task automatic t_slave_quiet();
        int drove = 0;
        is_master = 1'b0;
        arm = 1'b1;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (trig_out) drove++;
        end
        chk(drove == 0, "R6 slave never drives", drove, 0);
        arm = 1'b0;
    endtask

    // Two edges before the start merge; an edge during playback is ignored
    task automatic t_merge_ignore();
        int starts = 0, start_n = -1, wide = 0;
        do_align(0);
        for (int n = 1; n <= 60; n++) begin
            @(negedge clk);
            line_ext = (n == 6 || n == 7 || n == 10 || n == 11 || n == 17 || n == 18);
            if (start_pulse) begin
                starts++;
                if (start_n < 0) start_n = n;
            end
            if (start_pulse && n == start_n + 1) wide++;
        end
        line_ext = 1'b0;
        chk(start_n == 13, "R7 start cycle after slave edge", start_n, 13);
        chk(wide == 0, "R7 start one cycle", wide, 0);
        chk(starts == 1, "R8 extra edges ignored", starts, 1);
        chk(playing == 1, "R8 playback kept", playing, 1);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(playing == 0, "R9 stop", playing, 0);
    endtask

    task automatic t_stop_pending();
        int starts = 0;
        do_align(0);
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            line_ext = (n == 6 || n == 7);
            stop = (n == 10);
            if (start_pulse) starts++;
        end
        line_ext = 1'b0;
        stop = 1'b0;
        chk(starts == 0 && playing == 0, "R9 stop cancels pending", starts, 0);
    endtask

    task automatic t_rotation(input int len, input int rot, input int exp_start);
        int bad = 0, start_n = -1;
        wave_len = AW'(len);
        rot_ofs  = (AW+1)'(rot);
        do_align(0);
        for (int n = 1; n <= 13 + 3 * len; n++) begin
            @(negedge clk);
            line_ext = (n == 6 || n == 7);
            if (start_pulse) start_n = n;
            if (start_n > 0 && play_addr != AW'((exp_start + n - start_n) % len)) bad++;
        end
        line_ext = 1'b0;
        chk(start_n == 13, "R10 start seen", start_n, 13);
        chk(bad == 0, "R10 address sequence", bad, 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    initial begin
        t_reset();
        t_divider();
        t_clamp();
        t_align();
        t_master();
        t_slave_quiet();
        t_merge_ignore();
        t_stop_pending();
        t_rotation(7, 3, 3);
        t_rotation(7, -2, 5);
        t_rotation(7, 0, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule